// File: doc/BRIEF.md
# Local Interrupt Vectoring Unit

This block turns two local event sources into pending interrupt state. The sources are a performance-monitor overflow and a corrected machine check. Each source has its own control register, which holds an 8-bit target vector and a mask flag. When a source pulses for one cycle, the block checks that register. If the mask is clear and the vector is legal, the block sets the matching bit of a 256-entry pending bitmap. In every other case the event is dropped for good and leaves no trace.

Software programs and reads the two registers through a plain register port. The port has one select line and 64-bit data. Only the vector field and the mask flag hold state. Every other bit reads as zero, and writing it changes nothing. A separate acknowledge port clears one pending vector. Two things are left to downstream logic: choosing among the pending bits and delivering them to a core. Those consumers see the bitmap and a flag that is high when any bit is set.

Every input is accepted in the cycle it is presented, so no port has back-pressure. Events are single-cycle pulses with no ready signal. A write or an acknowledge that is held high for one cycle is taken exactly once.

Top module: `lvec_unit`

## Requirements
- R1: `cfg_sel` = 0 selects the performance-monitor register and 1 selects the corrected-machine-check register. In each register the vector sits in bits 7:0 and the mask in bit 16. A write stores both fields, and `cfg_rdata` returns them for the selected register in the same cycle.
- R2: Bits 63:17 and 15:8 of a register always read as zero. Writing ones to them leaves the stored vector and mask unchanged.
- R3: After reset both registers hold mask = 1 and vector = 0, and `pend_map` is all zero.
- R4: An event that arrives while its register's mask is 1 is discarded. Clearing the mask later does not pend it.
- R5: An event whose mask is 0 and whose vector is legal sets `pend_map[vector]`. The bit is visible after the next rising edge.
- R6: The legal vectors are 0, 2 and 16–255. An event whose register holds 1 or any value from 3 to 15 sets no bit.
- R7: A register write takes effect for events in later cycles. An event in the same cycle as the write uses the previous register contents.
- R8: If both sources fire in one cycle, both target bits are set. If both target the same vector, that one bit is set.
- R9: `ack_valid` with `ack_vector` clears that pending bit after the next edge. If an event sets the same vector in the same cycle, the bit stays set.
- R10: `pend_any` is high exactly when at least one bit of `pend_map` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the selected register |
| cfg_sel | input | 1 | Register select: 0 = performance monitor, 1 = corrected machine check |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data of the selected register |
| evt_perf | input | 1 | Performance-monitor overflow pulse |
| evt_cmc | input | 1 | Corrected machine check pulse |
| ack_valid | input | 1 | Clear request |
| ack_vector | input | 8 | Vector to clear |
| pend_map | output | 256 | Pending bitmap, one bit per vector |
| pend_any | output | 1 | OR of all pending bits |

## Verification
The drop assertions for masked and illegal vectors assume that no other source event and no acknowledge happen in the same cycle. Only under that condition can the bitmap be required to stay unchanged. The assertions also assume that the event inputs and `ack_valid` are known values whenever reset is released. The bench drives every input from one task a fixed time after the rising edge, so all inputs stay defined and none changes near an edge. The bench isolates the masked and illegal cases in their own cycles, and it mixes sources and acknowledges only in the steps that are aimed at R8 and R9.

// File: rtl/lvec_pkg.sv
package lvec_pkg;
  localparam int LV_VEC_W    = 8;
  localparam int LV_DATA_W   = 64;
  localparam int LV_MASK_POS = 16;
  localparam int LV_NUM_SRC  = 2;

  typedef struct packed {
    logic                masked;
    logic [LV_VEC_W-1:0] vec;
  } vcfg_t;

  function automatic logic lv_legal(input logic [LV_VEC_W-1:0] v);
    return (v == LV_VEC_W'(0)) || (v == LV_VEC_W'(2)) || (v >= LV_VEC_W'(16));
  endfunction
endpackage

// File: rtl/lvec_cfg_reg.sv
module lvec_cfg_reg
  import lvec_pkg::*;
#(
  parameter int DATA_W   = LV_DATA_W,
  parameter int MASK_POS = LV_MASK_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output vcfg_t             cfg,
  output logic [DATA_W-1:0] rdata
);
  logic [LV_VEC_W-1:0] vec_q;
  logic                mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q  <= '0;
      mask_q <= 1'b1;
    end else if (wr_en) begin
      vec_q  <= wdata[LV_VEC_W-1:0];
      mask_q <= wdata[MASK_POS];
    end
  end

  always_comb begin
    cfg.vec         = vec_q;
    cfg.masked      = mask_q;
    rdata           = '0;
    rdata[LV_VEC_W-1:0] = vec_q;
    rdata[MASK_POS] = mask_q;
  end

  // R7: contents move only on a write
  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(vec_q) && $stable(mask_q)));
endmodule

// File: rtl/lvec_filter.sv
module lvec_filter
  import lvec_pkg::*;
(
  input  logic                evt,
  input  vcfg_t               cfg,
  output logic                set_valid,
  output logic [LV_VEC_W-1:0] set_vec
);
  always_comb begin
    set_vec   = cfg.vec;
    set_valid = evt && !cfg.masked && lv_legal(cfg.vec);
  end
endmodule

// File: rtl/lvec_pend_map.sv
module lvec_pend_map
  import lvec_pkg::*;
#(
  parameter int NUM_SRC = LV_NUM_SRC,
  parameter int VEC_W   = LV_VEC_W,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_valid [NUM_SRC],
  input  logic [VEC_W-1:0]   set_vec   [NUM_SRC],
  input  logic               clr_valid,
  input  logic [VEC_W-1:0]   clr_vec,
  output logic [NUM_VEC-1:0] pend,
  output logic               any
);
  logic [NUM_VEC-1:0] pend_q, set_oh, clr_oh;

  always_comb begin
    set_oh = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (set_valid[s]) set_oh[set_vec[s]] = 1'b1;
    clr_oh = '0;
    if (clr_valid) clr_oh[clr_vec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_oh) | set_oh;
  end

  assign pend = pend_q;
  assign any  = |pend_q;

  // checker-side collision flag, built from the request ports
  logic clr_hit_by_set;
  always_comb begin
    clr_hit_by_set = 1'b0;
    for (int s = 0; s < NUM_SRC; s++)
      if (set_valid[s] && set_vec[s] == clr_vec) clr_hit_by_set = 1'b1;
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src_chk
      // R5 / R9: an accepted set lands even against a clear
      a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid[g] |=> pend_q[$past(set_vec[g])]);
    end
  endgenerate

  // R9: a clear without a colliding set empties the bit
  a_r9_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !clr_hit_by_set) |=> !pend_q[$past(clr_vec)]);

  // R8: no more new bits per cycle than there are sources
  a_r8_new_bits_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pend_q & ~$past(pend_q)) <= NUM_SRC);
endmodule

// File: rtl/lvec_unit.sv
module lvec_unit
  import lvec_pkg::*;
#(
  parameter int DATA_W   = LV_DATA_W,
  parameter int MASK_POS = LV_MASK_POS,
  localparam int NUM_SRC = LV_NUM_SRC,
  localparam int NUM_VEC = 1 << LV_VEC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic                cfg_sel,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic                evt_perf,
  input  logic                evt_cmc,
  input  logic                ack_valid,
  input  logic [LV_VEC_W-1:0] ack_vector,
  output logic [NUM_VEC-1:0]  pend_map,
  output logic                pend_any
);
  logic                src_evt   [NUM_SRC];
  vcfg_t               cfg_q     [NUM_SRC];
  logic [DATA_W-1:0]   src_rdata [NUM_SRC];
  logic                set_valid [NUM_SRC];
  logic [LV_VEC_W-1:0] set_vec   [NUM_SRC];

  assign src_evt[0] = evt_perf;
  assign src_evt[1] = evt_cmc;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      lvec_cfg_reg #(.DATA_W(DATA_W), .MASK_POS(MASK_POS)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr && (cfg_sel == 1'(g))),
        .wdata (cfg_wdata),
        .cfg   (cfg_q[g]),
        .rdata (src_rdata[g])
      );
      lvec_filter u_filt (
        .evt       (src_evt[g]),
        .cfg       (cfg_q[g]),
        .set_valid (set_valid[g]),
        .set_vec   (set_vec[g])
      );
    end
  endgenerate

  assign cfg_rdata = cfg_sel ? src_rdata[1] : src_rdata[0];

  lvec_pend_map #(.NUM_SRC(NUM_SRC), .VEC_W(LV_VEC_W)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_valid (set_valid),
    .set_vec   (set_vec),
    .clr_valid (ack_valid),
    .clr_vec   (ack_vector),
    .pend      (pend_map),
    .any       (pend_any)
  );

  // R4: a lone masked event leaves the bitmap untouched
  a_r4_masked_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_perf && cfg_q[0].masked && !evt_cmc && !ack_valid) |=> $stable(pend_map));

  // R6: a lone event aimed at a reserved vector leaves the bitmap untouched
  a_r6_illegal_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cmc && !cfg_q[1].masked && !evt_perf && !ack_valid &&
     (cfg_q[1].vec == 8'd1 || (cfg_q[1].vec >= 8'd3 && cfg_q[1].vec <= 8'd15)))
    |=> $stable(pend_map));
endmodule

// File: tb/lvec_unit_bench.sv
`timescale 1ns/1ps
module lvec_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [63:0]  cfg_wdata = '0, cfg_rdata;
  logic         evt_perf = 1'b0, evt_cmc = 1'b0, ack_valid = 1'b0;
  logic [7:0]   ack_vector = '0;
  logic [255:0] pend_map;
  logic         pend_any;

  always #2 clk = ~clk;

  lvec_unit u_lvec_unit (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard
  int           due_q [$];
  logic [255:0] map_q [$];
  string        tag_q [$];

  logic [255:0] m_map = '0;
  logic [7:0]   m_vec  [2] = '{8'd0, 8'd0};
  logic         m_mask [2] = '{1'b1, 1'b1};

  function automatic bit legal(input logic [7:0] v);
    return v == 0 || v == 2 || v >= 16;
  endfunction

  always @(negedge clk) begin
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      int d = due_q.pop_front();
      logic [255:0] e = map_q.pop_front();
      string t = tag_q.pop_front();
      n_chk++;
      if (pend_map !== e || pend_any !== (|e)) begin
        n_fail++;
        $display("FAIL %s: map=%h any=%b expected map=%h any=%b", t, pend_map, pend_any, e, |e);
      end
    end
  end

  task automatic step(input bit wr, input bit sel, input logic [63:0] wd,
                      input bit ep, input bit ec, input bit av,
                      input logic [7:0] avec, input string tag);
    logic [255:0] nx;
    @(posedge clk); #1;
    cfg_wr = wr; cfg_sel = sel; cfg_wdata = wd;
    evt_perf = ep; evt_cmc = ec; ack_valid = av; ack_vector = avec;
    nx = m_map;
    if (av) nx[avec] = 1'b0;
    if (ep && !m_mask[0] && legal(m_vec[0])) nx[m_vec[0]] = 1'b1;
    if (ec && !m_mask[1] && legal(m_vec[1])) nx[m_vec[1]] = 1'b1;
    if (wr) begin m_vec[sel] = wd[7:0]; m_mask[sel] = wd[16]; end
    m_map = nx;
    due_q.push_back(cyc + 1); map_q.push_back(nx); tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, '0, 0, 0, 0, '0, tag);
  endtask

  task automatic wr_cfg(input bit sel, input logic [7:0] v, input bit msk);
    step(1, sel, {47'h0, msk, 8'h00, v}, 0, 0, 0, '0, "R1 write");
  endtask

  task automatic readback(input bit sel, input logic [63:0] exp, input string tag);
    idle(tag);
    cfg_sel = sel;
    @(negedge clk);
    n_chk++;
    if (cfg_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%h expected %h", tag, cfg_rdata, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R3: reset state
    readback(0, 64'h1_0000, "R3 perf reset");
    readback(1, 64'h1_0000, "R3 cmc reset");
    idle("R3 map empty");
    // R4: masked event is lost
    step(0, 0, '0, 1, 0, 0, '0, "R4 masked perf");
    // R1/R2: write with reserved ones
    step(1, 0, 64'hFFFF_FFFF_FFFE_FF20, 0, 0, 0, '0, "R2 write");
    readback(0, 64'h0000_0000_0000_0020, "R2 reserved read zero");
    readback(1, 64'h1_0000, "R1 other register untouched");
    idle("R4 no late delivery");
    // R7: same-cycle write uses old vector
    step(1, 0, 64'h30, 1, 0, 0, '0, "R7 old vector 0x20");
    step(0, 0, '0, 1, 0, 0, '0, "R5 new vector 0x30");
    // R6: illegal vectors on cmc source
    wr_cfg(1, 8'd1, 0);  step(0, 0, '0, 0, 1, 0, '0, "R6 vec 1");
    wr_cfg(1, 8'd3, 0);  step(0, 0, '0, 0, 1, 0, '0, "R6 vec 3");
    wr_cfg(1, 8'd15, 0); step(0, 0, '0, 0, 1, 0, '0, "R6 vec 15");
    // R5/R6 legal edges
    wr_cfg(1, 8'd0, 0);   step(0, 0, '0, 0, 1, 0, '0, "R6 vec 0");
    wr_cfg(1, 8'd2, 0);   step(0, 0, '0, 0, 1, 0, '0, "R6 vec 2");
    wr_cfg(1, 8'd16, 0);  step(0, 0, '0, 0, 1, 0, '0, "R6 vec 16");
    wr_cfg(1, 8'd255, 0); step(0, 0, '0, 0, 1, 0, '0, "R5 vec 255");
    // R8: both sources
    wr_cfg(0, 8'h40, 0); wr_cfg(1, 8'h41, 0);
    step(0, 0, '0, 1, 1, 0, '0, "R8 two vectors");
    wr_cfg(1, 8'h50, 0); wr_cfg(0, 8'h50, 0);
    step(0, 0, '0, 1, 1, 0, '0, "R8 shared vector");
    // R9: ack clears, set wins
    step(0, 0, '0, 0, 0, 1, 8'h30, "R9 clear 0x30");
    step(0, 0, '0, 1, 0, 1, 8'h50, "R9 set wins 0x50");
    // R4: mask, event, unmask
    wr_cfg(0, 8'h60, 1);
    step(0, 0, '0, 1, 0, 0, '0, "R4 masked 0x60");
    wr_cfg(0, 8'h60, 0);
    idle("R4 unmask no delivery");
    // R10: clear everything
    for (int v = 0; v < 256; v++)
      if (m_map[v]) step(0, 0, '0, 0, 0, 1, 8'(v), "R10 drain");
    idle("R10 any low");
    idle("R10 settle");
    repeat (3) @(posedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule